// File: doc/BRIEF.md
# GPIO Edge Interrupt Controller

This block turns transitions on up to 64 general-purpose input lines into interrupt and wake requests. Every line passes through a two-flop synchronizer. Each line then watches for one kind of edge, rising or falling, which its own polarity bit selects. A detected edge sets a sticky status bit for that line. The bit stays set until software writes a one to it.

The lines are organized in banks of 32, and each bank has four registers:
- An enable mask. The OR of status ANDed with this mask drives a single registered interrupt output.
- A wake mask. The OR of status ANDed with this mask drives a registered wake output. The wake path ignores the interrupt enable mask.
- The polarity register.
- The status register.

Software reaches all of these through a simple word-wide register port. A read returns its data on the cycle after `rd_en`.

Top module: `pin_event_irq`

## Requirements
- R1: After a synchronous reset, every enable, polarity, status and wake register reads zero, and `irq_out` and `wake_out` are low.
- R2: With polarity bit 0, a 0-to-1 transition on a line sets its status bit, and a 1-to-0 transition leaves the status bit unchanged.
- R3: With polarity bit 1, a 1-to-0 transition on a line sets its status bit, and a 0-to-1 transition leaves the status bit unchanged.
- R4: A write to a status register clears each status bit where the written data holds 1 and leaves each bit where it holds 0 unchanged.
- R5: If an edge is detected on a line in the same cycle that a write of 1 clears its status bit, the bit ends up set.
- R6: A line whose enable bit is 0 still sets its status bit on an edge, but that bit does not raise `irq_out`.
- R7: `irq_out` is high exactly when some status bit has its enable bit set, and it follows that condition one cycle later.
- R8: `wake_out` is high exactly when some status bit has its wake bit set, regardless of the enable bits, and it follows that condition one cycle later.
- R9: Line n maps to bit n mod 32 of bank n div 32. The byte offsets are: enable at 0x00, polarity at 0x08, status at 0x10 and wake at 0x18, with the bank-1 copy of each 4 bytes higher. Enable, polarity and wake read back what was last written.
- R10: An edge on one line that arrives while another line's status is being cleared remains set in status, and `irq_out` stays high because of it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | NUM_LINES | Asynchronous line inputs |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte offset of the register |
| wdata | input | LINES_PER_BANK | Write data |
| rdata | output | LINES_PER_BANK | Read data, registered, valid the cycle after rd_en |
| irq_out | output | 1 | Combined interrupt request |
| wake_out | output | 1 | Combined wake request |

## Verification
The bench builds the block with its default parameters: 64 lines in two banks of 32, and a two-flop synchronizer. With these values, the bank-select address bit and the +4 register copies are exercised. The top line, 63, is exercised on the falling-edge path. A wake line in bank 1 checks that the wake path works apart from the bank-0 interrupt mask. With the fixed synchronizer depth, the bench can line up a status clear with the exact cycle in which an edge is detected.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;

  // Register kind, taken from the upper address bits.
  typedef enum logic [1:0] {
    KIND_ENABLE   = 2'd0,
    KIND_POLARITY = 2'd1,
    KIND_STATUS   = 2'd2,
    KIND_WAKE     = 2'd3
  } reg_kind_e;

  localparam int WORD_BYTE_BITS = 2;  // registers are 4 bytes apart
  localparam int KIND_BITS      = 2;

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int WIDTH  = 64,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '0;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/bank_event.sv
module bank_event
  import pin_irq_pkg::*;
#(
  parameter int W = 32
) (
  input  logic      clk,
  input  logic      rst,
  input  logic [W-1:0] line_s,
  input  logic      wr_hit,
  input  reg_kind_e kind,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] en_q,
  output logic [W-1:0] pol_q,
  output logic [W-1:0] wake_q,
  output logic [W-1:0] stat_q,
  output logic      irq_any,
  output logic      wake_any
);

  logic [W-1:0] prev_q;
  logic [W-1:0] rise_v, fall_v, edge_v, clr_v, stat_d;
  logic         stat_wr;

  assign rise_v  = line_s & ~prev_q;
  assign fall_v  = ~line_s & prev_q;
  assign edge_v  = (rise_v & ~pol_q) | (fall_v & pol_q);
  assign stat_wr = wr_hit && (kind == KIND_STATUS);
  assign clr_v   = stat_wr ? wdata : '0;
  // a fresh edge outranks a simultaneous clear
  assign stat_d  = (stat_q & ~clr_v) | edge_v;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      stat_q <= '0;
      en_q   <= '0;
      pol_q  <= '0;
      wake_q <= '0;
    end else begin
      prev_q <= line_s;
      stat_q <= stat_d;
      if (wr_hit) begin
        case (kind)
          KIND_ENABLE:   en_q   <= wdata;
          KIND_POLARITY: pol_q  <= wdata;
          KIND_WAKE:     wake_q <= wdata;
          default:       ;
        endcase
      end
    end
  end

  assign irq_any  = |(stat_q & en_q);
  assign wake_any = |(stat_q & wake_q);

  // R4: a written 1 leaves the bit clear unless an edge came in that cycle
  assert_w1c_R4: assert property (@(posedge clk) disable iff (rst)
    stat_wr |=> ((stat_q & $past(wdata) & ~$past(edge_v)) == '0));

  // R5: every detected edge shows up in status on the next cycle
  assert_set_wins_R5: assert property (@(posedge clk) disable iff (rst)
    (|edge_v) |=> ((stat_q & $past(edge_v)) == $past(edge_v)));

  // R10: without a status write, set bits are never lost
  assert_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    !stat_wr |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

endmodule

// File: rtl/pin_event_irq.sv
module pin_event_irq
  import pin_irq_pkg::*;
#(
  parameter int NUM_LINES      = 64,
  parameter int LINES_PER_BANK = 32,
  parameter int SYNC_STAGES    = 2,
  localparam int NUM_BANKS     = NUM_LINES / LINES_PER_BANK,
  localparam int BANK_W        = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int ADDR_W        = WORD_BYTE_BITS + BANK_W + KIND_BITS
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_LINES-1:0]      pin_in,
  input  logic                      wr_en,
  input  logic                      rd_en,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [LINES_PER_BANK-1:0] wdata,
  output logic [LINES_PER_BANK-1:0] rdata,
  output logic                      irq_out,
  output logic                      wake_out
);

  localparam int LPB = LINES_PER_BANK;

  logic [NUM_LINES-1:0] line_s;
  reg_kind_e            kind;
  logic [BANK_W-1:0]    bank_idx;

  logic [LPB-1:0] en_b   [NUM_BANKS];
  logic [LPB-1:0] pol_b  [NUM_BANKS];
  logic [LPB-1:0] wake_b [NUM_BANKS];
  logic [LPB-1:0] stat_b [NUM_BANKS];
  logic [NUM_BANKS-1:0] irq_b, wake_req_b;

  assign kind     = reg_kind_e'(addr[ADDR_W-1 -: KIND_BITS]);
  assign bank_idx = addr[WORD_BYTE_BITS +: BANK_W];

  pin_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(line_s)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit = wr_en && (bank_idx == BANK_W'(b));
    bank_event #(.W(LPB)) u_bank (
      .clk(clk), .rst(rst),
      .line_s(line_s[b*LPB +: LPB]),
      .wr_hit(hit), .kind(kind), .wdata(wdata),
      .en_q(en_b[b]), .pol_q(pol_b[b]), .wake_q(wake_b[b]), .stat_q(stat_b[b]),
      .irq_any(irq_b[b]), .wake_any(wake_req_b[b])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata    <= '0;
      irq_out  <= 1'b0;
      wake_out <= 1'b0;
    end else begin
      irq_out  <= |irq_b;
      wake_out <= |wake_req_b;
      if (rd_en) begin
        rdata <= '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
          if (bank_idx == BANK_W'(b)) begin
            case (kind)
              KIND_ENABLE:   rdata <= en_b[b];
              KIND_POLARITY: rdata <= pol_b[b];
              KIND_STATUS:   rdata <= stat_b[b];
              KIND_WAKE:     rdata <= wake_b[b];
              default:       rdata <= '0;
            endcase
          end
        end
      end
    end
  end

  // R6: with no enabled status bit in any bank, the interrupt is low next cycle
  assert_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    (irq_b == '0) |=> !irq_out);

  // R7: an enabled status bit in any bank raises the interrupt next cycle
  assert_irq_R7: assert property (@(posedge clk) disable iff (rst)
    (|irq_b) |=> irq_out);

  // R8: the wake output follows the wake-masked banks one cycle later
  assert_wake_R8: assert property (@(posedge clk) disable iff (rst)
    (|wake_req_b) |=> wake_out);

  assert_wake_low_R8: assert property (@(posedge clk) disable iff (rst)
    (wake_req_b == '0) |=> !wake_out);

endmodule

// File: tb/sim_pin_event_irq.sv
module sim_pin_event_irq;

  logic        clk = 0;
  logic        rst;
  logic [63:0] pins;
  logic        wr_en, rd_en;
  logic [4:0]  addr;
  logic [31:0] wdata, rdata;
  logic        irq_out, wake_out;
  int total = 0, bad = 0;
  bit finished = 0;

  localparam logic [4:0] A_EN0 = 5'h00, A_EN1 = 5'h04, A_POL0 = 5'h08, A_POL1 = 5'h0C;
  localparam logic [4:0] A_ST0 = 5'h10, A_ST1 = 5'h14, A_WK0 = 5'h18, A_WK1 = 5'h1C;

  always #5 clk = ~clk;

  pin_event_irq u0 (
    .clk(clk), .rst(rst), .pin_in(pins), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_out(irq_out), .wake_out(wake_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 irq", {31'd0, irq_out}, 0);
    chk("R1 wake", {31'd0, wake_out}, 0);
    for (int i = 0; i < 8; i++) begin
      rd(5'(i * 4), v);
      chk("R1 reg", v, 0);
    end
  endtask

  task automatic t_map();
    logic [31:0] v;
    wr(A_EN0, 32'hA5A5_0001); rd(A_EN0, v); chk("R9 en0", v, 32'hA5A5_0001);
    rd(A_EN1, v); chk("R9 en1 untouched", v, 0);
    wr(A_POL1, 32'h8000_0001); rd(A_POL1, v); chk("R9 pol1", v, 32'h8000_0001);
    rd(A_POL0, v); chk("R9 pol0 untouched", v, 0);
    wr(A_WK1, 32'h0000_0100); rd(A_WK1, v); chk("R9 wk1", v, 32'h0000_0100);
    wr(A_EN0, 0); wr(A_POL1, 32'h8000_0000); wr(A_WK1, 0);
  endtask

  task automatic t_rise();
    logic [31:0] v;
    @(negedge clk); pins[3] = 1; settle();
    rd(A_ST0, v); chk("R2 rise sets", v, 32'h8);
    wr(A_ST0, 0); rd(A_ST0, v); chk("R4 write0 keeps", v, 32'h8);
    wr(A_ST0, 32'h8); rd(A_ST0, v); chk("R4 write1 clears", v, 0);
    @(negedge clk); pins[3] = 0; settle();
    rd(A_ST0, v); chk("R2 fall ignored", v, 0);
  endtask

  task automatic t_fall();
    logic [31:0] v;
    @(negedge clk); pins[63] = 1; settle();
    rd(A_ST1, v); chk("R3 rise ignored", v, 0);
    @(negedge clk); pins[63] = 0; settle();
    rd(A_ST1, v); chk("R3 fall sets line63", v, 32'h8000_0000);
    rd(A_ST0, v); chk("R9 bank0 untouched", v, 0);
    wr(A_ST1, 32'h8000_0000); rd(A_ST1, v); chk("R4 clear bank1", v, 0);
  endtask

  task automatic t_mask();
    logic [31:0] v;
    @(negedge clk); pins[5] = 1; settle();
    rd(A_ST0, v); chk("R6 disabled latches", v, 32'h20);
    chk("R6 no irq", {31'd0, irq_out}, 0);
    wr(A_EN0, 32'h20); @(negedge clk);
    chk("R7 irq on enable", {31'd0, irq_out}, 1);
    wr(A_ST0, 32'h20); @(negedge clk);
    chk("R7 irq after clear", {31'd0, irq_out}, 0);
    wr(A_EN0, 0);
  endtask

  task automatic t_wake();
    @(negedge clk); pins[40] = 1; wr(A_WK1, 32'h100); settle();
    chk("R8 wake", {31'd0, wake_out}, 1);
    chk("R8 irq stays low", {31'd0, irq_out}, 0);
    wr(A_ST1, 32'h100); @(negedge clk);
    chk("R8 wake clears", {31'd0, wake_out}, 0);
    wr(A_WK1, 0);
  endtask

  task automatic t_service();
    logic [31:0] v;
    wr(A_EN0, 32'h6);
    @(negedge clk); pins[1] = 1; settle();
    chk("R10 irq line1", {31'd0, irq_out}, 1);
    @(negedge clk); pins[2] = 1;
    wr(A_ST0, 32'h2); settle();
    rd(A_ST0, v); chk("R10 line2 kept", v, 32'h4);
    chk("R10 irq still", {31'd0, irq_out}, 1);
    wr(A_ST0, 32'h4); wr(A_EN0, 0);
  endtask

  task automatic t_set_wins();
    logic [31:0] v;
    @(negedge clk); pins[7] = 1; settle();
    @(negedge clk); pins[7] = 0; settle();
    rd(A_ST0, v); chk("R5 pre set", v, 32'h80);
    @(negedge clk); pins[7] = 1;
    @(negedge clk);
    @(negedge clk); wr_en = 1; addr = A_ST0; wdata = 32'h80;
    @(negedge clk); wr_en = 0;
    rd(A_ST0, v); chk("R5 set wins", v, 32'h80);
    wr(A_ST0, 32'h80); rd(A_ST0, v); chk("R5 later clear", v, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1; pins = '0; wr_en = 0; rd_en = 0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_map();
    t_rise();
    t_fall();
    t_mask();
    t_wake();
    t_service();
    t_set_wins();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule